// File: doc/BRIEF.md
# Fan Speed Ramp Controller

This block owns the 8-bit speed code for a fan drive. Software writes a target speed and a ramp control word through two register write strobes. With ramping off, a new target reaches the speed output directly. With ramping on, an internal up/down counter walks the output toward the target one code per step. The step interval comes from a prescaler that divides the system clock into base ticks, then counts a selectable power-of-two number of ticks per step.

Ramping is enabled by a bit in the control word. When it is switched on, the counter already holds the target value, so the speed does not jump. A new target written while a ramp is in progress is chased from wherever the counter is, in either direction. Switching ramping off drops the output straight to the target. A separate force input from an external over-temperature path drives the output to full scale and leaves the counter untouched, so the ramp picks up where it was once the force is removed. Both reset inputs are synchronous and active high.

Top module: `fan_ramp_ctrl`

## Requirements
- R1: Either reset input (`rst` or `aux_rst`) clears the target, the ramp control word and the counter to zero. `speed_out` reads 0x00 on the clock edge after the reset is seen. After a reset, ramping is off.
- R2: While ramping is off (control bit 0 = 0), a value written to the target register appears on `speed_out` on the second rising edge after the write strobe is sampled.
- R3: Bit 0 of the ramp control word enables ramping. Setting it leaves `speed_out` unchanged until a new target is written.
- R4: While ramping is on, the counter changes by exactly one code on each step pulse, in the direction of the target. It holds its value between step pulses.
- R5: Control bits [3:1] hold a rate code k from 0 to 7. Steps are spaced DIV × 2^k clocks apart, where DIV is the base tick divider (default 4). The prescaler restarts from zero whenever ramping is off.
- R6: The counter stops when it equals the target and never moves past it. This limits it to the range 0x00 to 0xFF.
- R7: A target written during a ramp is followed from the current counter value. The counter reverses direction if the new target lies on the other side.
- R8: While `force_full` is high, `speed_out` reads 0xFF on the following edge and the counter keeps running. After release, `speed_out` resumes from the counter value.
- R9: Clearing the enable bit during a ramp makes `speed_out` jump to the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aux_rst | input | 1 | Second synchronous reset, active high, same effect as `rst` |
| tgt_we | input | 1 | Write strobe for the target speed register |
| tgt_wdata | input | 8 | Target speed value to write |
| ctl_we | input | 1 | Write strobe for the ramp control register |
| ctl_wdata | input | 8 | Control word: bit 0 enables ramping, bits [3:1] set the rate code, other bits are ignored |
| force_full | input | 1 | Override that drives the output to full scale |
| speed_out | output | 8 | Registered fan speed code |

## Verification
The assertions assume that all inputs change only between rising clock edges and that the base divider is at least two, so two step pulses can never fall on adjacent cycles. They also assume that a reset is held high from time zero until the first edge. The stimulus drives every input on falling edges, holds `rst` from the start, and uses the default divider. Control writes, target changes, force pulses and the auxiliary reset land at arbitrary points within a ramp, and never on the same edge as a reset.

// File: rtl/fan_ramp_pkg.sv
package fan_ramp_pkg;
  localparam int SPD_W  = 8;
  localparam int RATE_W = 3;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              en;
  } ramp_ctl_t;
endpackage

// File: rtl/fan_ramp_regs.sv
module fan_ramp_regs #(
  parameter int SPD_W  = fan_ramp_pkg::SPD_W,
  parameter int RATE_W = fan_ramp_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tgt_we,
  input  logic [SPD_W-1:0]  tgt_wdata,
  input  logic              ctl_we,
  input  logic [SPD_W-1:0]  ctl_wdata,
  output logic [SPD_W-1:0]  target_q,
  output logic [SPD_W-1:0]  target_nxt,
  output logic              en_q,
  output logic [RATE_W-1:0] rate_q
);
  localparam int CTL_W = RATE_W + 1;

  logic [CTL_W-1:0] ctl_q;

  assign target_nxt = tgt_we ? tgt_wdata : target_q;
  assign en_q       = ctl_q[0];
  assign rate_q     = ctl_q[CTL_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
      ctl_q    <= '0;
    end else begin
      target_q <= target_nxt;
      if (ctl_we) ctl_q <= ctl_wdata[CTL_W-1:0];
    end
  end
endmodule

// File: rtl/fan_ramp_tick.sv
module fan_ramp_tick #(
  parameter int DIV    = 4,
  parameter int RATE_W = fan_ramp_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              step
);
  localparam int BASE_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int STEP_W = (1 << RATE_W) - 1;

  logic [BASE_W-1:0] base_q;
  logic [STEP_W-1:0] stp_q;
  logic [STEP_W-1:0] lim;
  logic              tick;

  assign lim  = {STEP_W{1'b1}} >> (STEP_W - int'(rate));
  assign tick = en && (base_q == BASE_W'(DIV - 1));
  assign step = tick && (stp_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      base_q <= '0;
      stp_q  <= '0;
    end else begin
      base_q <= tick ? '0 : base_q + 1'b1;
      if (step)      stp_q <= '0;
      else if (tick) stp_q <= stp_q + 1'b1;
    end
  end

  assert_step_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);
endmodule

// File: rtl/fan_ramp_cnt.sv
module fan_ramp_cnt #(
  parameter int SPD_W = fan_ramp_pkg::SPD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step,
  input  logic [SPD_W-1:0] target,
  input  logic [SPD_W-1:0] target_nxt,
  output logic [SPD_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (!en)                     cnt <= target_nxt;
    else if (step && (cnt < target))  cnt <= cnt + 1'b1;
    else if (step && (cnt > target))  cnt <= cnt - 1'b1;
  end

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
    en |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt)));

  assert_idle_between_steps_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !step) |=> $stable(cnt));

  assert_no_overshoot_R6: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == target) |=> $stable(cnt));
endmodule

// File: rtl/fan_ramp_ctrl.sv
module fan_ramp_ctrl #(
  parameter int SPD_W  = fan_ramp_pkg::SPD_W,
  parameter int RATE_W = fan_ramp_pkg::RATE_W,
  parameter int DIV    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aux_rst,
  input  logic             tgt_we,
  input  logic [SPD_W-1:0] tgt_wdata,
  input  logic             ctl_we,
  input  logic [SPD_W-1:0] ctl_wdata,
  input  logic             force_full,
  output logic [SPD_W-1:0] speed_out
);
  logic              rst_any;
  logic [SPD_W-1:0]  target_q, target_nxt, cnt;
  logic              en_q, step;
  logic [RATE_W-1:0] rate_q;

  assign rst_any = rst | aux_rst;

  fan_ramp_regs #(.SPD_W(SPD_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst_any),
    .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .target_q(target_q), .target_nxt(target_nxt),
    .en_q(en_q), .rate_q(rate_q)
  );

  fan_ramp_tick #(.DIV(DIV), .RATE_W(RATE_W)) u_tick (
    .clk(clk), .rst(rst_any), .en(en_q), .rate(rate_q), .step(step)
  );

  fan_ramp_cnt #(.SPD_W(SPD_W)) u_cnt (
    .clk(clk), .rst(rst_any), .en(en_q), .step(step),
    .target(target_q), .target_nxt(target_nxt), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst_any)         speed_out <= '0;
    else if (force_full) speed_out <= '1;
    else                 speed_out <= cnt;
  end

  assert_force_full_R8: assert property (@(posedge clk) disable iff (rst_any)
    force_full |=> (speed_out == {SPD_W{1'b1}}));
endmodule

// File: tb/fan_ramp_ctrl_tb.sv
`timescale 1ns/1ps
module fan_ramp_ctrl_tb;
  localparam int DIV = 4;

  logic       clk = 0, rst = 1, aux_rst = 0, tgt_we = 0, ctl_we = 0, force_full = 0;
  logic [7:0] tgt_wdata = 0, ctl_wdata = 0;
  logic [7:0] speed_out;

  int vectors = 0, fails = 0, cycles = 0;
  bit run_cmp = 0;
  string phase = "R1";

  int m_tgt = 0, m_en = 0, m_rate = 0, m_cnt = 0, m_base = 0, m_stp = 0, m_out = 0;

  fan_ramp_ctrl #(.DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .aux_rst(aux_rst), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .force_full(force_full), .speed_out(speed_out)
  );

  always #10 clk = ~clk;

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    int nt;
    bit tick, stepp;
    if (rst || aux_rst) begin
      m_tgt = 0; m_en = 0; m_rate = 0; m_cnt = 0; m_base = 0; m_stp = 0; m_out = 0;
    end else begin
      tick  = (m_en != 0) && (m_base == DIV - 1);
      stepp = tick && (m_stp >= (1 << m_rate) - 1);
      nt    = tgt_we ? int'(tgt_wdata) : m_tgt;
      m_out = force_full ? 255 : m_cnt;
      if (m_en == 0)                   m_cnt = nt;
      else if (stepp && m_cnt < m_tgt) m_cnt = m_cnt + 1;
      else if (stepp && m_cnt > m_tgt) m_cnt = m_cnt - 1;
      if (m_en == 0) begin
        m_base = 0; m_stp = 0;
      end else begin
        m_base = tick ? 0 : m_base + 1;
        m_stp  = stepp ? 0 : (tick ? m_stp + 1 : m_stp);
      end
      m_tgt = nt;
      if (ctl_we) begin
        m_en = int'(ctl_wdata[0]); m_rate = int'(ctl_wdata[3:1]);
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (run_cmp) begin
      vectors++;
      if (int'(speed_out) != m_out) begin
        fails++;
        $display("FAIL %s cycle %0d: speed_out actual=%02h expected=%02h", phase, cycles, speed_out, m_out);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(int exp, string tag);
    vectors++;
    if (int'(speed_out) != exp) begin
      fails++;
      $display("FAIL %s: speed_out actual=%02h expected=%02h", tag, speed_out, exp);
    end
  endtask

  task automatic wr_tgt(logic [7:0] v);
    tgt_we = 1; tgt_wdata = v;
    @(negedge clk);
    tgt_we = 0;
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_we = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 0;
  endtask

  initial begin
    // R1: reset from time zero
    wait_cyc(3);
    run_cmp = 1;
    expect_out(8'h00, "R1 reset value");
    rst = 0;

    // R2: ramp off, writes go straight through
    phase = "R2";
    wr_tgt(8'h40);
    wait_cyc(2);
    expect_out(8'h40, "R2 direct write");
    wr_tgt(8'h10);
    wait_cyc(2);
    expect_out(8'h10, "R2 second direct write");

    // R3: enabling does not move the output
    phase = "R3";
    wr_ctl(8'h01);
    wait_cyc(6);
    expect_out(8'h10, "R3 enable holds output");

    // R4 R6: ramp up at rate 0
    phase = "R4";
    wr_tgt(8'h20);
    wait_cyc(20);
    if (speed_out <= 8'h10 || speed_out >= 8'h20) begin
      fails++;
      $display("FAIL R4 mid-ramp: speed_out actual=%02h expected=between 10 and 20", speed_out);
    end
    vectors++;
    wait_cyc(80);
    expect_out(8'h20, "R6 settled at target");

    // R5: rate 3, ramp down
    phase = "R5";
    wr_ctl(8'h07);
    wr_tgt(8'h1C);
    wait_cyc(200);
    expect_out(8'h1C, "R5 rate 3 ramp down");

    // R7: reverse mid-ramp
    phase = "R7";
    wr_ctl(8'h01);
    wr_tgt(8'h80);
    wait_cyc(40);
    wr_tgt(8'h00);
    wait_cyc(250);
    expect_out(8'h00, "R7 reversed to zero");

    // R8: force during a ramp
    phase = "R8";
    wr_tgt(8'hFF);
    wait_cyc(20);
    force_full = 1;
    wait_cyc(10);
    expect_out(8'hFF, "R8 forced full");
    force_full = 0;
    wait_cyc(2);
    if (speed_out == 8'hFF) begin
      fails++;
      $display("FAIL R8 release: speed_out actual=%02h expected=counter value", speed_out);
    end
    vectors++;
    wait_cyc(1100);
    expect_out(8'hFF, "R6 saturated at full");

    // R9: disable mid-ramp
    phase = "R9";
    wr_tgt(8'h00);
    wait_cyc(40);
    wr_ctl(8'h00);
    wait_cyc(3);
    expect_out(8'h00, "R9 disable jumps to target");

    // R1: auxiliary reset mid-ramp
    phase = "R1";
    wr_ctl(8'h01);
    wr_tgt(8'h50);
    wait_cyc(20);
    aux_rst = 1;
    @(negedge clk);
    aux_rst = 0;
    wait_cyc(1);
    expect_out(8'h00, "R1 aux reset clears output");
    wr_tgt(8'h33);
    wait_cyc(2);
    expect_out(8'h33, "R1 aux reset cleared enable");

    // R5: slowest rate
    phase = "R5";
    wr_ctl(8'h0F);
    wr_tgt(8'h35);
    wait_cyc(300);
    expect_out(8'h33, "R5 rate 7 no early step");
    wait_cyc(800);
    expect_out(8'h35, "R5 rate 7 reached target");

    summary();
    $finish;
  end
endmodule